// File: doc/BRIEF.md
# Lighting-control packet transmitter

This block sends one complete lighting-control packet on a single serial line each time it receives a start pulse. The packet opens with the line held low for a fixed break interval. A shorter high interval follows the break. The line then carries a continuous run of asynchronous serial characters at 250 kbit/s. At the 16 MHz default clock, one bit lasts 64 cycles: a prescale of 4 feeds a 16x oversample divider.

The first sixteen characters of each packet come from a small bank of byte registers, sent in ascending index order. A simple write port loads these registers. Every character after those sixteen carries zero, and the packet stops after the configured number of characters (512 by default). The register contents are copied when a packet is accepted. A write made while a packet is on the line therefore only reaches the next packet. A status output shows that a packet is in progress, and a one-cycle pulse marks its completion. Line drivers, direction control and any receive path belong to surrounding logic.

Top module: `lightframe_tx`

## Requirements
- R1: After reset the serial output is high, the busy output is low and the done output is low.
- R2: A start pulse sampled while idle sets busy in the next cycle and drives the output low for exactly BREAK_CYCLES clock cycles.
- R3: Right after the break, the output is high for exactly MARK_CYCLES clock cycles before the first start bit.
- R4: Each character has one start bit at 0, then 8 data bits least significant bit first, then STOP_BITS stop bits at 1. There is no parity bit, and each bit lasts CLK_PRESCALE*OVERSAMPLE clock cycles.
- R5: Characters 0 to SLOT_COUNT-1 carry slot registers 0 to SLOT_COUNT-1 in that order. A write with wr_en_i high stores wr_data_i into the slot selected by wr_addr_i.
- R6: Characters SLOT_COUNT to PACKET_BYTES-1 carry the value 0x00.
- R7: Characters follow each other without gaps: a start bit begins in the cycle right after the previous character's last stop-bit cycle.
- R8: Busy stays high until the last stop bit of character PACKET_BYTES-1 ends. In the following cycle busy is low, done is high for exactly one cycle, and the output is high. The output stays high whenever busy is low.
- R9: A start pulse that arrives while busy is ignored. The packet in progress is unchanged, and no further packet follows it.
- R10: The slot registers are copied when a start is accepted. A slot write during a packet does not change that packet and appears in the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Single-cycle request to send a packet |
| wr_en_i | input | 1 | Slot register write strobe |
| wr_addr_i | input | $clog2(SLOT_COUNT) | Slot index for a write |
| wr_data_i | input | 8 | Byte to store in the addressed slot |
| busy_o | output | 1 | High while a packet is on the line |
| done_o | output | 1 | One-cycle pulse after the final stop bit |
| tx_o | output | 1 | Serial line output, idles high |

## Verification
Two situations are hard to reach from the ports: a slot write and a start request that both land in the middle of the data phase of a running packet. To reach them, the bench counts clock cycles from the accepted start and fires the write and the extra start while characters are being sent. It then checks the packet in progress and the one after it, character by character. A line monitor decodes the serial output and measures the break and mark lengths. Because a packet is long at the defaults, the bench shrinks the divider, break, mark and packet length through the parameters. Timing and zero-padding boundaries are therefore crossed several times in a short run.

// File: rtl/lft_pkg.sv
// Shared definitions for the lighting-control packet transmitter.
// Assumes: characters always carry 8 data bits.
package lft_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MARK,
        ST_DATA
    } lft_state_e;
endpackage

// File: rtl/lft_baud_gen.sv
// Bit-period timer: emits bit_tick_o once every PRESCALE*OVERSAMPLE cycles while
// en_i is high, counted from the first enabled cycle.
// Assumes: counters restart whenever en_i is low.
module lft_baud_gen #(
    parameter int PRESCALE   = 4,
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic bit_tick_o
);
    localparam int OSW     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int BIT_LEN = PRESCALE * OVERSAMPLE;

    logic           os_tick;
    logic [OSW-1:0] os_cnt;

    generate
        if (PRESCALE == 1) begin : g_noprescale
            assign os_tick = en_i;
        end else begin : g_prescale
            localparam int PW = $clog2(PRESCALE);
            logic [PW-1:0] pre_cnt;
            // Divide the clock down to the oversample rate.
            always_ff @(posedge clk) begin
                if (!rst_n || !en_i)                 pre_cnt <= '0;
                else if (pre_cnt == PW'(PRESCALE-1)) pre_cnt <= '0;
                else                                 pre_cnt <= pre_cnt + 1'b1;
            end
            assign os_tick = en_i && (pre_cnt == PW'(PRESCALE-1));
        end
    endgenerate

    // Count oversample ticks within one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)                     os_cnt <= '0;
        else if (os_tick) begin
            if (os_cnt == OSW'(OVERSAMPLE-1))    os_cnt <= '0;
            else                                 os_cnt <= os_cnt + 1'b1;
        end
    end

    assign bit_tick_o = os_tick && (os_cnt == OSW'(OVERSAMPLE-1));

    // Checker: cycles since the last tick, used to confirm the bit length.
    logic [31:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || bit_tick_o) gap_q <= '0;
        else                               gap_q <= gap_q + 1;
    end

    assert_bit_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> (gap_q == 32'(BIT_LEN - 1)));
endmodule

// File: rtl/lft_slot_file.sv
// Programmable slot bytes: a live bank written from the port and a snapshot bank
// copied in one cycle on snap_i. Reads always come from the snapshot.
// Assumes: a write in the same cycle as snap_i reaches only the live bank.
module lft_slot_file #(
    parameter int SLOTS = 16,
    parameter int AW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [lft_pkg::DATA_W-1:0] wr_data_i,
    input  logic                      snap_i,
    input  logic [AW-1:0]             rd_idx_i,
    output logic [lft_pkg::DATA_W-1:0] rd_data_o
);
    logic [lft_pkg::DATA_W-1:0] live_q [SLOTS];
    logic [lft_pkg::DATA_W-1:0] snap_q [SLOTS];

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            // Hold the software-written value of slot i.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 live_q[i] <= '0;
                else if (wr_en_i && wr_addr_i == AW'(i))    live_q[i] <= wr_data_i;
            end
            // Freeze slot i for the packet being started.
            always_ff @(posedge clk) begin
                if (!rst_n)      snap_q[i] <= '0;
                else if (snap_i) snap_q[i] <= live_q[i];
            end
        end
    endgenerate

    assign rd_data_o = snap_q[rd_idx_i];
endmodule

// File: rtl/lft_char_shifter.sv
// Serializes one character: start bit, DATA_W data bits LSB first, STOP_BITS
// stop bits. Shifts one bit per bit_tick_i; char_end_o flags the last bit's tick.
// Assumes: load_i may coincide with the final tick and then takes priority.
module lft_char_shifter #(
    parameter int STOP_BITS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [lft_pkg::DATA_W-1:0] load_data_i,
    input  logic                       bit_tick_i,
    output logic                       tx_bit_o,
    output logic                       char_end_o
);
    localparam int FB = 1 + lft_pkg::DATA_W + STOP_BITS;
    localparam int IW = $clog2(FB);

    logic [FB-1:0] shreg_q;
    logic [IW-1:0] idx_q;

    // Load a framed character or shift the next bit onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            idx_q   <= '0;
        end else if (load_i) begin
            shreg_q <= {{STOP_BITS{1'b1}}, load_data_i, 1'b0};
            idx_q   <= '0;
        end else if (bit_tick_i) begin
            shreg_q <= {1'b1, shreg_q[FB-1:1]};
            idx_q   <= (idx_q == IW'(FB-1)) ? '0 : idx_q + 1'b1;
        end
    end

    assign tx_bit_o   = shreg_q[0];
    assign char_end_o = bit_tick_i && (idx_q == IW'(FB-1));

    assert_stop_bits_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idx_q) > lft_pkg::DATA_W) |-> tx_bit_o);
endmodule

// File: rtl/lightframe_tx.sv
// Top of the packet transmitter: break, mark, then PACKET_BYTES back-to-back
// characters, the first SLOT_COUNT from the slot file and the rest zero.
// Assumes: PACKET_BYTES > SLOT_COUNT, both break and mark at least one cycle.
module lightframe_tx #(
    parameter int CLK_PRESCALE = 4,
    parameter int OVERSAMPLE   = 16,
    parameter int BREAK_CYCLES = 1408,
    parameter int MARK_CYCLES  = 128,
    parameter int SLOT_COUNT   = 16,
    parameter int PACKET_BYTES = 512,
    parameter int STOP_BITS    = 2,
    localparam int SAW         = $clog2(SLOT_COUNT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       wr_en_i,
    input  logic [SAW-1:0]             wr_addr_i,
    input  logic [lft_pkg::DATA_W-1:0] wr_data_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       tx_o
);
    import lft_pkg::*;

    localparam int TMAX = (BREAK_CYCLES > MARK_CYCLES) ? BREAK_CYCLES : MARK_CYCLES;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(PACKET_BYTES + 1);

    lft_state_e          state_q;
    logic [CW-1:0]       cyc_q;
    logic [BW-1:0]       byte_q;
    logic [BW-1:0]       next_idx;
    logic                accept, mark_end, last_char;
    logic                bit_tick, char_end, shift_bit, load_char;
    logic [DATA_W-1:0]   slot_byte, load_byte;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign mark_end  = (state_q == ST_MARK) && (cyc_q == CW'(MARK_CYCLES-1));
    assign last_char = (byte_q == BW'(PACKET_BYTES-1));
    assign next_idx  = (state_q == ST_MARK) ? '0 : byte_q + 1'b1;
    assign load_char = mark_end || ((state_q == ST_DATA) && char_end && !last_char);
    assign load_byte = (int'(next_idx) < SLOT_COUNT) ? slot_byte : '0;

    lft_slot_file #(.SLOTS(SLOT_COUNT), .AW(SAW)) slots_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .snap_i(accept), .rd_idx_i(next_idx[SAW-1:0]), .rd_data_o(slot_byte)
    );

    lft_baud_gen #(.PRESCALE(CLK_PRESCALE), .OVERSAMPLE(OVERSAMPLE)) baud_i (
        .clk(clk), .rst_n(rst_n), .en_i(state_q == ST_DATA), .bit_tick_o(bit_tick)
    );

    lft_char_shifter #(.STOP_BITS(STOP_BITS)) shift_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_char), .load_data_i(load_byte),
        .bit_tick_i(bit_tick), .tx_bit_o(shift_bit), .char_end_o(char_end)
    );

    // Packet sequencer: idle, timed break, timed mark, character stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            byte_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_BREAK;
                    cyc_q   <= '0;
                end
                ST_BREAK: if (cyc_q == CW'(BREAK_CYCLES-1)) begin
                    state_q <= ST_MARK;
                    cyc_q   <= '0;
                end else cyc_q <= cyc_q + 1'b1;
                ST_MARK: if (mark_end) begin
                    state_q <= ST_DATA;
                    byte_q  <= '0;
                end else cyc_q <= cyc_q + 1'b1;
                ST_DATA: if (char_end) begin
                    if (last_char) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end else byte_q <= byte_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line level for each phase.
    always_comb begin
        unique case (state_q)
            ST_BREAK: tx_o = 1'b0;
            ST_DATA:  tx_o = shift_bit;
            default:  tx_o = 1'b1;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);

    assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_at_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));
    assert_break_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o);
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && start_i) |=> (state_q == ST_DATA || state_q == ST_IDLE));
endmodule

// File: tb/lightframe_tx_tb_top.sv
// Scoreboard bench: the driver queues the expected characters of each packet,
// and a line monitor decodes tx_o and compares each character with the queue.
module lightframe_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRE  = 2;
    localparam int OS   = 2;
    localparam int BIT  = PRE * OS;
    localparam int BRK  = 10;
    localparam int MAB  = 3;
    localparam int NSL  = 16;
    localparam int PKT  = 20;
    localparam int WDOG = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       busy_o, done_o, tx_o;

    int checks = 0;
    int fails  = 0;
    int pkts_done = 0;
    logic [7:0] model_slots [NSL];
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lightframe_tx #(
        .CLK_PRESCALE(PRE), .OVERSAMPLE(OS), .BREAK_CYCLES(BRK), .MARK_CYCLES(MAB),
        .SLOT_COUNT(NSL), .PACKET_BYTES(PKT), .STOP_BITS(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .busy_o(busy_o), .done_o(done_o), .tx_o(tx_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic write_slot(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        model_slots[a] = d;
    endtask

    // Driver: push the expected characters, then pulse start.
    task automatic run_packet();
        for (int i = 0; i < PKT; i++) exp_q.push_back(i < NSL ? model_slots[i] : 8'h00);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o === 1'b1, "R2", "busy after start", int'(busy_o), 1);
    endtask

    // Monitor: decode the line and compare with the scoreboard queue.
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            int n;
            int m;
            @(negedge clk);
            while (tx_o !== 1'b0) @(negedge clk);
            n = 0;
            while (tx_o === 1'b0) begin n++; @(negedge clk); end
            chk(n == BRK, "R2", "break length", n, BRK);
            m = 0;
            while (tx_o === 1'b1) begin m++; @(negedge clk); end
            chk(m == MAB, "R3", "mark length", m, MAB);
            for (int b = 0; b < PKT; b++) begin
                logic [7:0] got;
                logic [7:0] exp;
                bit frame_ok;
                chk(tx_o === 1'b0, "R7", $sformatf("start edge of char %0d", b), int'(tx_o), 0);
                repeat (BIT/2) @(negedge clk);
                frame_ok = (tx_o === 1'b0);
                for (int k = 0; k < 8; k++) begin
                    repeat (BIT) @(negedge clk);
                    got[k] = tx_o;
                end
                repeat (BIT) @(negedge clk);
                frame_ok &= (tx_o === 1'b1);
                repeat (BIT) @(negedge clk);
                frame_ok &= (tx_o === 1'b1);
                chk(frame_ok, "R4", $sformatf("start/stop bits of char %0d", b), int'(frame_ok), 1);
                exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                chk(got === exp, (b < NSL) ? "R5" : "R6",
                    $sformatf("char %0d value", b), int'(got), int'(exp));
                repeat (BIT/2) @(negedge clk);
            end
            chk(done_o === 1'b1 && busy_o === 1'b0 && tx_o === 1'b1, "R8",
                "done/busy/tx after last stop", {done_o, busy_o, tx_o}, 3'b101);
            @(negedge clk);
            chk(done_o === 1'b0, "R8", "done width", int'(done_o), 0);
            pkts_done++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WDOG) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected packet completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NSL; i++) model_slots[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(tx_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
            "reset outputs", {tx_o, busy_o, done_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_o === 1'b1 && busy_o === 1'b0, "R1", "idle after reset", {tx_o, busy_o}, 2'b10);

        // Packet 1: walking and edge patterns.
        for (int i = 0; i < NSL; i++)
            write_slot(i, (i == 0) ? 8'h01 : (i == 1) ? 8'h80 : (i == 2) ? 8'hFF :
                          8'((i * 37) ^ 8'h5A));
        run_packet();
        wait (pkts_done == 1);

        // Packet 2: alternating bits, extra start in the data phase.
        for (int i = 0; i < NSL; i++) write_slot(i, (i % 2 == 0) ? 8'h55 : 8'hAA);
        run_packet();
        repeat (BRK + MAB + 30) @(negedge clk);
        chk(busy_o === 1'b1, "R9", "busy before extra start", int'(busy_o), 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (pkts_done == 2);
        begin
            bit quiet = 1'b1;
            repeat (3 * BRK) begin
                @(negedge clk);
                quiet &= (tx_o === 1'b1) && (busy_o === 1'b0);
            end
            chk(quiet, "R9", "no packet after ignored start", int'(quiet), 1);
        end

        // Packet 3: slot writes during the packet; packet 4 must carry them.
        run_packet();
        repeat (BRK + MAB + 20) @(negedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 4'd0; wr_data_i = 8'hC3;
        @(negedge clk);
        wr_addr_i = 4'd15; wr_data_i = 8'h3C;
        @(negedge clk);
        wr_en_i = 1'b0;
        model_slots[0]  = 8'hC3;
        model_slots[15] = 8'h3C;
        wait (pkts_done == 3);
        run_packet();
        wait (pkts_done == 4);
        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule